// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block gathers transfer-completion events from a set of DMA channels (up to 32) into one level-sensitive interrupt line for the host. Each channel reports completion with a single-cycle pulse. The pulse latches into that channel's bit of a raw status register, whatever the channel's enable bit holds, so software that keeps a channel masked can still poll for completion and clear the bit itself.

Software reaches three 32-bit registers over a simple register bus. The raw status register is write-one-to-clear. The enable register is plain read/write. The pending register is read-only and shows status ANDed with enable. The interrupt line is a register output. It is high while any pending bit is set. Writing zero to the enable register masks every channel at once and leaves the latched status as it was. Bit n of every register belongs to channel n.

The bus has a write strobe and a read strobe. Read data is registered and shows on the clock after the read strobe. At every other time the read data is zero.

Top module: `dma_irq_agg`

## Requirements
- R1: After a synchronous reset every status and enable bit is 0, the interrupt output is low and the read data is 0.
- R2: A done pulse on channel n sets status bit n at the next clock edge, whatever enable bit n holds, and the bit stays set until software clears it.
- R3: A write to the status register at offset 0x080000 clears each status bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0. Writing 0xFFFFFFFF clears all channels.
- R4: When a done pulse and a clearing write hit the same status bit in the same cycle, the bit is set after that edge.
- R5: The enable register at offset 0x080008 takes the written value for bits 0 to NUM_CH-1 and reads back that value. Bits at NUM_CH and above read as 0.
- R6: A read of the pending register at offset 0x080004 returns status AND enable.
- R7: Writes to the pending offset, and writes to any unmapped offset, change no status or enable bit. Reads of unmapped offsets return 0.
- R8: The interrupt output is high in the cycle after any pending bit is 1. It goes low on the clock after the last pending bit clears.
- R9: Writing 0 to the enable register drops the interrupt on the next clock and keeps every status bit. Enabling the channels again brings the interrupt back.
- R10: Read data for a read strobe shows on the clock edge after the strobe. It returns to 0 on the following edge if no read follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| done_i | input | NUM_CH | One-cycle completion pulse, one bit per channel |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, valid on the clock after reg_rd |
| irq_o | output | 1 | Registered, level-sensitive host interrupt |

## Verification
A channel's done pulse and software's write-one-to-clear can land on the same status bit in the same cycle. The bench provokes this by driving the pulse and the clearing write in the same cycle, on a write that also clears a second bit that has no pulse. It then requires that the colliding bit is still set and the other bit is cleared. A second overlap is between re-enabling a channel and a status bit that was latched while the channel was masked. The bench checks that the interrupt comes back one clock after the enable write, and that every pending value over all 256 enable patterns of an 8-channel build equals status AND enable as computed in the bench.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned REG_W = 32;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_PEND = 2'd2,
    SEL_EN   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
  import irq_agg_pkg::*;
#(
  parameter int unsigned     ADDR_W   = 20,
  parameter logic [ADDR_W-1:0] STAT_OFS = 20'h80000,
  parameter logic [ADDR_W-1:0] PEND_OFS = 20'h80004,
  parameter logic [ADDR_W-1:0] EN_OFS   = 20'h80008
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    if (addr_i == STAT_OFS)      sel_o = SEL_STAT;
    else if (addr_i == PEND_OFS) sel_o = SEL_PEND;
    else if (addr_i == EN_OFS)   sel_o = SEL_EN;
    else                         sel_o = SEL_NONE;
  end
endmodule

// File: rtl/irq_agg_status.sv
module irq_agg_status #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] done_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] st_q
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)            st_q[g] <= 1'b0;
      else if (done_i[g]) st_q[g] <= 1'b1;
      else if (clr_i[g])  st_q[g] <= 1'b0;
    end
  end

  AST_STAT_RESET: assert property (@(posedge clk) rst |=> (st_q == '0)); // R1
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (rst)
    (|done_i) |=> ((st_q & $past(done_i)) == $past(done_i))); // R2
  AST_CLR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & ~done_i)) |=> ((st_q & $past(clr_i & ~done_i)) == '0)); // R3
  AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & done_i)) |=> ((st_q & $past(clr_i & done_i)) == $past(clr_i & done_i))); // R4
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((done_i == '0) && (clr_i == '0)) |=> $stable(st_q)); // R3
endmodule

// File: rtl/irq_agg_enable.sv
module irq_agg_enable #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst)       en_q <= '0;
    else if (wr_i) en_q <= wdata_i;
  end

  AST_EN_RESET: assert property (@(posedge clk) rst |=> (en_q == '0)); // R1
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(en_q)); // R7
endmodule

// File: rtl/irq_agg_readback.sv
module irq_agg_readback
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  reg_sel_e          sel_i,
  input  logic [NUM_CH-1:0] stat_i,
  input  logic [NUM_CH-1:0] pend_i,
  input  logic [NUM_CH-1:0] en_i,
  output logic [REG_W-1:0]  rdata_q
);
  logic [REG_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (rd_i) begin
      unique case (sel_i)
        SEL_STAT: rd_next[NUM_CH-1:0] = stat_i;
        SEL_PEND: rd_next[NUM_CH-1:0] = pend_i;
        SEL_EN:   rd_next[NUM_CH-1:0] = en_i;
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> (rdata_q == '0)); // R10
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned       NUM_CH   = 32,
  parameter int unsigned       ADDR_W   = 20,
  parameter logic [ADDR_W-1:0] STAT_OFS = 20'h80000,
  parameter logic [ADDR_W-1:0] PEND_OFS = 20'h80004,
  parameter logic [ADDR_W-1:0] EN_OFS   = 20'h80008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] done_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_o
);
  reg_sel_e          sel;
  logic [NUM_CH-1:0] stat_w;
  logic [NUM_CH-1:0] en_w;
  logic [NUM_CH-1:0] pend_w;
  logic [NUM_CH-1:0] clr_w;
  logic              en_wr;
  logic              irq_q;

  irq_agg_decode #(
    .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .PEND_OFS(PEND_OFS), .EN_OFS(EN_OFS)
  ) u_dec (
    .addr_i(reg_addr),
    .sel_o (sel)
  );

  assign clr_w = (reg_wr && sel == SEL_STAT) ? reg_wdata[NUM_CH-1:0] : '0;
  assign en_wr = reg_wr && (sel == SEL_EN);

  irq_agg_status #(.NUM_CH(NUM_CH)) u_stat (
    .clk   (clk),
    .rst   (rst),
    .done_i(done_i),
    .clr_i (clr_w),
    .st_q  (stat_w)
  );

  irq_agg_enable #(.NUM_CH(NUM_CH)) u_en (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (en_wr),
    .wdata_i(reg_wdata[NUM_CH-1:0]),
    .en_q   (en_w)
  );

  assign pend_w = stat_w & en_w;

  irq_agg_readback #(.NUM_CH(NUM_CH)) u_rb (
    .clk    (clk),
    .rst    (rst),
    .rd_i   (reg_rd),
    .sel_i  (sel),
    .stat_i (stat_w),
    .pend_i (pend_w),
    .en_i   (en_w),
    .rdata_q(reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend_w;
  end
  assign irq_o = irq_q;

  AST_IRQ_RESET: assert property (@(posedge clk) rst |=> !irq_o); // R1
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
    (|(stat_w & en_w)) |=> irq_o); // R8
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (rst)
    ((stat_w & en_w) == '0) |=> !irq_o); // R8
  AST_EN_TAKES: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == EN_OFS) |=> (en_w == $past(reg_wdata[NUM_CH-1:0]))); // R5
  AST_PEND_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == PEND_OFS && done_i == '0) |=> ($stable(stat_w) && $stable(en_w))); // R7
  AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == EN_OFS && reg_wdata == '0) |=> ((stat_w & $past(stat_w)) == $past(stat_w))); // R9
endmodule

// File: tb/dma_irq_agg_tb_top.sv
`timescale 1ns/1ps
module dma_irq_agg_tb_top;
  localparam int unsigned NCH = 8;
  localparam logic [19:0] A_STAT = 20'h80000;
  localparam logic [19:0] A_PEND = 20'h80004;
  localparam logic [19:0] A_EN   = 20'h80008;
  localparam logic [19:0] A_BAD  = 20'h80010;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NCH-1:0]  done_i = '0;
  logic [19:0]     reg_addr = '0;
  logic            reg_wr = 1'b0;
  logic            reg_rd = 1'b0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            irq_o;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [NCH-1:0] mstat = '0;
  logic [NCH-1:0] men = '0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  dma_irq_agg #(.NUM_CH(NCH), .ADDR_W(20)) dut_i (
    .clk(clk), .rst(rst), .done_i(done_i), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic bus_read(input logic [19:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [NCH-1:0] m);
    @(negedge clk);
    done_i = m;
    @(negedge clk);
    done_i = '0;
  endtask

  function automatic logic [31:0] ext(input logic [NCH-1:0] v);
    logic [31:0] r;
    r = '0;
    r[NCH-1:0] = v;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    chk("R1 rdata", reg_rdata, 32'd0);
    bus_read(A_STAT, rv); chk("R1 status", rv, 32'd0);
    bus_read(A_EN, rv);   chk("R1 enable", rv, 32'd0);

    // R10 read latency: data on the edge after the strobe, zero after
    @(negedge clk);
    reg_addr = A_EN; reg_wdata = 32'h5A; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b1;
    chk("R10 before edge", reg_rdata, 32'd0);
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R10 data", reg_rdata, 32'h5A);
    @(negedge clk);
    chk("R10 idle zero", reg_rdata, 32'd0);
    bus_write(A_EN, 32'd0);

    // R2 per-channel sweep while masked, then per-bit clear (R3)
    for (int ch = 0; ch < NCH; ch++) begin
      pulse(NCH'(1) << ch);
      mstat = mstat | (NCH'(1) << ch);
      bus_read(A_STAT, rv); chk("R2 set while masked", rv, ext(mstat));
      bus_read(A_PEND, rv); chk("R6 masked pending", rv, 32'd0);
      chk("R8 masked irq", {31'd0, irq_o}, 32'd0);
    end
    for (int ch = 0; ch < NCH; ch++) begin
      bus_write(A_STAT, 32'd1 << ch);
      mstat = mstat & ~(NCH'(1) << ch);
      bus_read(A_STAT, rv); chk("R3 single clear", rv, ext(mstat));
    end

    // R5 upper bits read as zero
    bus_write(A_EN, 32'hFFFF_FFFF);
    bus_read(A_EN, rv); chk("R5 width", rv, 32'h0000_00FF);

    // R6/R8 exhaustive enable sweep
    for (int e = 0; e < 256; e++) begin
      logic [NCH-1:0] s;
      s = NCH'((e * 37 + 11) & 8'hFF);
      bus_write(A_STAT, 32'hFFFF_FFFF);
      bus_write(A_EN, 32'(e));
      men = NCH'(e);
      pulse(s);
      mstat = s;
      bus_read(A_EN, rv);   chk("R5 enable readback", rv, ext(men));
      bus_read(A_PEND, rv); chk("R6 pending", rv, ext(mstat & men));
      chk("R8 irq level", {31'd0, irq_o}, {31'd0, |(mstat & men)});
    end

    // R3 clear all
    bus_write(A_STAT, 32'hFFFF_FFFF);
    mstat = '0;
    bus_read(A_STAT, rv); chk("R3 clear all", rv, 32'd0);

    // R8 precise rise and fall
    bus_write(A_EN, 32'hFF); men = '1;
    @(negedge clk);
    chk("R8 idle low", {31'd0, irq_o}, 32'd0);
    pulse(8'h10);
    chk("R8 not yet high", {31'd0, irq_o}, 32'd0);
    @(negedge clk);
    chk("R8 high one clock later", {31'd0, irq_o}, 32'd1);
    bus_write(A_STAT, 32'h10);
    chk("R8 still high", {31'd0, irq_o}, 32'd1);
    @(negedge clk);
    chk("R8 low after last clear", {31'd0, irq_o}, 32'd0);

    // R4 collision: done and clear on bit 2, clear only on bit 5
    pulse(8'h24);
    @(negedge clk);
    reg_addr = A_STAT; reg_wdata = 32'h24; reg_wr = 1'b1; done_i = 8'h04;
    @(negedge clk);
    reg_wr = 1'b0; done_i = '0;
    bus_read(A_STAT, rv); chk("R4 collision keeps", rv, 32'h04);

    // R7 writes to pending and unmapped are ignored
    bus_write(A_PEND, 32'hFFFF_FFFF);
    bus_write(A_BAD, 32'hFFFF_FFFF);
    bus_read(A_STAT, rv); chk("R7 status kept", rv, 32'h04);
    bus_read(A_EN, rv);   chk("R7 enable kept", rv, 32'hFF);
    bus_read(A_BAD, rv);  chk("R7 unmapped read", rv, 32'd0);

    // R9 mask all keeps status, re-enable restores irq
    chk("R9 irq before mask", {31'd0, irq_o}, 32'd1);
    bus_write(A_EN, 32'd0);
    @(negedge clk);
    chk("R9 irq masked", {31'd0, irq_o}, 32'd0);
    bus_read(A_STAT, rv); chk("R9 status kept", rv, 32'h04);
    bus_write(A_EN, 32'h04);
    @(negedge clk);
    chk("R9 irq restored", {31'd0, irq_o}, 32'd1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule